// File: doc/BRIEF.md
# Two-Trace Adaptive Threshold Spiking Neuron

This block is a discrete-time, fixed-point spiking neuron. On every time-step strobe it leaks its membrane potential by a fixed factor, adds a signed input current and compares the membrane with a firing threshold. The threshold is not fixed. It is a programmable baseline plus two weighted adaptation traces. One trace decays quickly and the other slowly. Each firing event bumps both traces, so a neuron that fires often becomes harder to excite. When the neuron stays silent, its threshold slides back to the baseline first along a fast curve and then along a slow one.

All fixed-point values share 16 fractional bits. The membrane, input current, baseline and threshold are signed words of `MEM_W` bits. Decay factors and weights are unsigned fractions in [0, 1), and the traces are unsigned with two integer bits. The surrounding network drives one strobe per time step and reads the spike and the current threshold. Configuration inputs are sampled combinationally and are expected to be held steady between steps. For useful behaviour, the slow time constant should be more than six times the fast one.

Top module: `twin_trace_neuron`

## Requirements
- R1: While reset or `clear_i` is high, the membrane and both traces are set to zero and `spike_o` is low, so `thr_o` equals `base_i` on the cycle after.
- R2: `thr_o` = `base_i` + floor(`beta_fast_i`·trace_fast / 2^16) + floor(`beta_slow_i`·trace_slow / 2^16). The weights are unsigned, with value/2^16. The sum is clamped to the largest positive `MEM_W`-bit value.
- R3: On each strobe, trace k becomes floor(rho_k·trace_k / 2^16) + (spike ? 2^16 − rho_k : 0), clamped at 2^18 − 1. The fast trace uses `rho_fast_i` and the slow trace uses `rho_slow_i`. Both traces update independently on the same strobe.
- R4: On a strobe without a spike, the membrane becomes (membrane·`LEAK` / 2^16, rounded toward zero) + `cur_i`, clamped to the signed `MEM_W`-bit limits.
- R5: A strobe produces a spike exactly when the membrane held before the strobe is strictly greater than `thr_o` before the strobe (signed compare). Equality does not fire.
- R6: A strobe that produces a spike sets the membrane to zero instead of integrating the input.
- R7: Without a strobe and with steady configuration, the membrane, traces and `thr_o` hold, whatever `cur_i` does.
- R8: With no spikes, both traces decay to zero and `thr_o` returns exactly to `base_i`.
- R9: `spike_o` is high only on the cycle right after a strobe that fired, and never after a cycle with `clear_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Synchronous state clear |
| strobe_i | input | 1 | Time-step strobe, one cycle per step |
| cur_i | input | MEM_W | Signed input current, 16 fractional bits |
| rho_fast_i | input | 16 | Decay factor of the fast trace |
| rho_slow_i | input | 16 | Decay factor of the slow trace |
| beta_fast_i | input | 16 | Weight of the fast trace in the threshold |
| beta_slow_i | input | 16 | Weight of the slow trace in the threshold |
| base_i | input | MEM_W | Signed baseline threshold |
| spike_o | output | 1 | Spike pulse, one cycle after a firing strobe |
| thr_o | output | MEM_W | Current adaptive threshold |

## Verification
The bench builds the neuron with `MEM_W` = 24 and `LEAK` = 0xE000 (0.875). With these values the membrane reaches both signed rails within a few steps of full-scale input. A baseline placed one LSB below the rail then exposes both the strict comparison and the threshold clamp. The decay factors 0x8000 and 0xF000 give a slow trace that settles within a few hundred steps, so the bench can observe the full return to baseline. Weights near full scale let a single spike visibly lift the threshold.

// File: rtl/ttn_pkg.sv
package ttn_pkg;

    localparam int FRAC_W  = 16;
    localparam int FACT_W  = 16;
    localparam int TRACE_W = FRAC_W + 2;
    localparam int N_TRACE = 2;
    localparam int MUL_W   = FACT_W + TRACE_W;

    localparam int IDX_FAST = 0;
    localparam int IDX_SLOW = 1;

    typedef logic [FACT_W-1:0]  fact_t;
    typedef logic [TRACE_W-1:0] trace_t;

    typedef struct packed {
        fact_t rho;
        fact_t beta;
    } trace_cfg_t;

    localparam trace_t TRACE_MAX = {TRACE_W{1'b1}};

    // unsigned fraction times trace, truncated (toward zero)
    function automatic trace_t frac_mul(fact_t f, trace_t t);
        logic [MUL_W-1:0] p;
        p = MUL_W'(f) * MUL_W'(t);
        return p[FRAC_W +: TRACE_W];
    endfunction

    // increment applied on a spike: one minus the decay factor
    function automatic logic [FRAC_W:0] spike_bump(fact_t rho);
        return (FRAC_W+1)'(1 << FRAC_W) - (FRAC_W+1)'(rho);
    endfunction

    function automatic trace_t trace_next(trace_t t, fact_t rho, logic fire);
        logic [TRACE_W:0] s;
        s = (TRACE_W+1)'(frac_mul(rho, t));
        if (fire) begin
            s = s + (TRACE_W+1)'(spike_bump(rho));
        end
        if (s[TRACE_W]) begin
            return TRACE_MAX;
        end
        return s[TRACE_W-1:0];
    endfunction

endpackage

// File: rtl/ttn_trace.sv
module ttn_trace
    import ttn_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   clear_i,
    input  logic   step_i,
    input  logic   fire_i,
    input  fact_t  rho_i,
    output trace_t trace_o
);

    trace_t trace_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            trace_q <= '0;
        end else if (step_i) begin
            trace_q <= trace_next(trace_q, rho_i, fire_i);
        end
    end

    assign trace_o = trace_q;

endmodule

// File: rtl/ttn_membrane.sv
module ttn_membrane
    import ttn_pkg::*;
#(
    parameter int          MEM_W = 24,
    parameter logic [15:0] LEAK  = 16'hE000
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    clear_i,
    input  logic                    step_i,
    input  logic                    fire_i,
    input  logic signed [MEM_W-1:0] cur_i,
    output logic signed [MEM_W-1:0] mem_o
);

    localparam int PROD_W = MEM_W + FACT_W + 1;
    localparam logic signed [MEM_W-1:0] MEM_MAX = {1'b0, {(MEM_W-1){1'b1}}};
    localparam logic signed [MEM_W-1:0] MEM_MIN = {1'b1, {(MEM_W-1){1'b0}}};
    localparam logic [PROD_W-1:0] RTZ_BIAS = PROD_W'((1 << FRAC_W) - 1);

    logic signed [MEM_W-1:0]  mem_q;
    logic signed [PROD_W-1:0] mem_ext;
    logic signed [PROD_W-1:0] leak_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] shifted;
    logic signed [MEM_W-1:0]  leaked;
    logic signed [MEM_W:0]    sum;
    logic signed [MEM_W-1:0]  integ;

    always_comb begin
        mem_ext  = {{(FACT_W+1){mem_q[MEM_W-1]}}, mem_q};
        leak_ext = PROD_W'(LEAK);
        prod     = mem_ext * leak_ext;
        // bias negative products so the arithmetic shift rounds toward zero
        biased   = prod[PROD_W-1] ? (prod + RTZ_BIAS) : prod;
        shifted  = biased >>> FRAC_W;
        leaked   = shifted[MEM_W-1:0];
        sum      = {leaked[MEM_W-1], leaked} + {cur_i[MEM_W-1], cur_i};
        if (sum[MEM_W] != sum[MEM_W-1]) begin
            integ = sum[MEM_W] ? MEM_MIN : MEM_MAX;
        end else begin
            integ = sum[MEM_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            mem_q <= '0;
        end else if (step_i) begin
            mem_q <= fire_i ? '0 : integ;
        end
    end

    assign mem_o = mem_q;

endmodule

// File: rtl/ttn_threshold.sv
module ttn_threshold
    import ttn_pkg::*;
#(
    parameter int MEM_W = 24
) (
    input  logic signed [MEM_W-1:0] base_i,
    input  trace_t                  trace_i [N_TRACE],
    input  fact_t                   beta_i  [N_TRACE],
    output logic signed [MEM_W-1:0] thr_o
);

    localparam int ACC_W = MEM_W + 2;
    localparam logic signed [MEM_W-1:0] THR_MAX = {1'b0, {(MEM_W-1){1'b1}}};

    trace_t                  contrib [N_TRACE];
    logic signed [ACC_W-1:0] acc;

    for (genvar k = 0; k < N_TRACE; k++) begin : g_contrib
        assign contrib[k] = frac_mul(beta_i[k], trace_i[k]);
    end

    always_comb begin
        acc = {{2{base_i[MEM_W-1]}}, base_i};
        for (int k = 0; k < N_TRACE; k++) begin
            acc = acc + ACC_W'(contrib[k]);
        end
        // contributions are never negative, so only the upper rail is reachable
        if (acc[ACC_W-1:MEM_W-1] != {3{acc[MEM_W-1]}}) begin
            thr_o = THR_MAX;
        end else begin
            thr_o = acc[MEM_W-1:0];
        end
    end

endmodule

// File: rtl/twin_trace_neuron.sv
module twin_trace_neuron
    import ttn_pkg::*;
#(
    parameter int          MEM_W = 24,
    parameter logic [15:0] LEAK  = 16'hE000
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    clear_i,
    input  logic                    strobe_i,
    input  logic signed [MEM_W-1:0] cur_i,
    input  logic [15:0]             rho_fast_i,
    input  logic [15:0]             rho_slow_i,
    input  logic [15:0]             beta_fast_i,
    input  logic [15:0]             beta_slow_i,
    input  logic signed [MEM_W-1:0] base_i,
    output logic                    spike_o,
    output logic signed [MEM_W-1:0] thr_o
);

    trace_cfg_t              cfg   [N_TRACE];
    fact_t                   betas [N_TRACE];
    trace_t                  traces[N_TRACE];
    logic signed [MEM_W-1:0] mem_q;
    logic signed [MEM_W-1:0] thr_now;
    logic                    fire;
    logic                    step;
    logic                    spike_q;

    assign cfg[IDX_FAST] = '{rho: rho_fast_i, beta: beta_fast_i};
    assign cfg[IDX_SLOW] = '{rho: rho_slow_i, beta: beta_slow_i};

    assign step = strobe_i && !clear_i;
    // compare against the pre-update membrane and threshold
    assign fire = step && (mem_q > thr_now);

    for (genvar k = 0; k < N_TRACE; k++) begin : g_trace
        assign betas[k] = cfg[k].beta;
        ttn_trace u_trace (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .clear_i (clear_i),
            .step_i  (step),
            .fire_i  (fire),
            .rho_i   (cfg[k].rho),
            .trace_o (traces[k])
        );
    end

    ttn_membrane #(
        .MEM_W (MEM_W),
        .LEAK  (LEAK)
    ) u_membrane (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (clear_i),
        .step_i  (step),
        .fire_i  (fire),
        .cur_i   (cur_i),
        .mem_o   (mem_q)
    );

    ttn_threshold #(
        .MEM_W (MEM_W)
    ) u_threshold (
        .base_i  (base_i),
        .trace_i (traces),
        .beta_i  (betas),
        .thr_o   (thr_now)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            spike_q <= 1'b0;
        end else begin
            spike_q <= fire;
        end
    end

    assign spike_o = spike_q;
    assign thr_o   = thr_now;

endmodule

// File: rtl/ttn_checker.sv
module ttn_checker #(
    parameter int MEM_W = 24
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    clear_i,
    input logic                    strobe_i,
    input logic [15:0]             beta_fast_i,
    input logic [15:0]             beta_slow_i,
    input logic signed [MEM_W-1:0] base_i,
    input logic                    spike_o,
    input logic signed [MEM_W-1:0] thr_o,
    input logic signed [MEM_W-1:0] mem_i
);

    // R9: a spike follows a strobe that was not overridden by a clear
    a_r9_spike_after_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        spike_o |-> ($past(strobe_i) && !$past(clear_i)));

    // R6: a firing step leaves the membrane at zero
    a_r6_mem_zero_on_fire: assert property (@(posedge clk_i) disable iff (rst_i)
        spike_o |-> (mem_i == '0));

    // R1: clear returns the neuron to its resting state
    a_r1_clear_rest: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> (!spike_o && mem_i == '0 && thr_o == base_i));

    // R2: adaptation only ever raises the threshold
    a_r2_thr_at_least_base: assert property (@(posedge clk_i) disable iff (rst_i)
        thr_o >= base_i);

    // R7: without a step and with steady configuration nothing moves
    a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(strobe_i) && !$past(clear_i) && !$past(rst_i) &&
         $stable(base_i) && $stable(beta_fast_i) && $stable(beta_slow_i))
        |-> ($stable(thr_o) && $stable(mem_i)));

endmodule

bind twin_trace_neuron ttn_checker #(.MEM_W(MEM_W)) u_ttn_checker (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .clear_i     (clear_i),
    .strobe_i    (strobe_i),
    .beta_fast_i (beta_fast_i),
    .beta_slow_i (beta_slow_i),
    .base_i      (base_i),
    .spike_o     (spike_o),
    .thr_o       (thr_o),
    .mem_i       (mem_q)
);

// File: tb/twin_trace_neuron_bench.sv
`timescale 1ns/1ps
module twin_trace_neuron_bench;

    localparam int          MEM_W = 24;
    localparam logic [15:0] LEAK  = 16'hE000;
    localparam longint MAXV = (64'sd1 <<< (MEM_W-1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (MEM_W-1));
    localparam longint TMAX = (64'sd1 <<< 18) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic strobe = 1'b0;
    logic signed [MEM_W-1:0] cur = '0;
    logic [15:0] rho_f = 16'h8000, rho_s = 16'hF000, beta_f = '0, beta_s = '0;
    logic signed [MEM_W-1:0] base = 24'sh010000;
    logic spike;
    logic signed [MEM_W-1:0] thr;

    always #2.5ns clk = ~clk;

    twin_trace_neuron #(.MEM_W(MEM_W), .LEAK(LEAK)) u_twin_trace_neuron (
        .clk_i(clk), .rst_i(rst), .clear_i(clear), .strobe_i(strobe), .cur_i(cur),
        .rho_fast_i(rho_f), .rho_slow_i(rho_s), .beta_fast_i(beta_f), .beta_slow_i(beta_s),
        .base_i(base), .spike_o(spike), .thr_o(thr)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        bit     spk;
        longint thr;
        string  req;
    } exp_t;
    exp_t exp_q[$];

    // reference state
    longint m_v = 0, m_t1 = 0, m_t2 = 0;

    task automatic chk(string req, longint act, longint expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint ref_thr(longint t1, longint t2);
        longint s;
        s = longint'(base) + ((longint'(beta_f) * t1) >>> 16) + ((longint'(beta_s) * t2) >>> 16);
        return (s > MAXV) ? MAXV : s;
    endfunction

    function automatic longint ref_trace(longint t, longint rho, bit f);
        longint s;
        s = (rho * t) >>> 16;
        if (f) s = s + (65536 - rho);
        return (s > TMAX) ? TMAX : s;
    endfunction

    function automatic longint ref_mem(longint v, longint c);
        longint p, l, s;
        p = v * longint'(LEAK);
        l = (p < 0) ? -((-p) >>> 16) : (p >>> 16);
        s = l + c;
        if (s > MAXV) s = MAXV;
        if (s < MINV) s = MINV;
        return s;
    endfunction

    // driver: one time step, expectation pushed to the scoreboard
    task automatic step(longint c, string req);
        exp_t e;
        bit f;
        @(negedge clk);
        strobe = 1'b1;
        cur = c[MEM_W-1:0];
        f = (m_v > ref_thr(m_t1, m_t2));
        m_t1 = ref_trace(m_t1, longint'(rho_f), f);
        m_t2 = ref_trace(m_t2, longint'(rho_s), f);
        m_v  = f ? 0 : ref_mem(m_v, c);
        e.spk = f;
        e.thr = ref_thr(m_t1, m_t2);
        e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        m_v = 0; m_t1 = 0; m_t2 = 0;
        @(negedge clk);
        clear = 1'b0;
        chk("R1 thr after clear", longint'(thr), longint'(base));
        chk("R1 spike after clear", longint'(spike), 0);
    endtask

    // monitor
    logic seen = 1'b0;
    always @(posedge clk) seen <= strobe && !rst && !clear;

    always @(negedge clk) begin
        if (seen) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard empty", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.req, " spike"}, longint'(spike), longint'(e.spk));
                chk({e.req, " thr"}, longint'(thr), e.thr);
            end
        end else if (!rst) begin
            chk("R9 no spike without strobe", longint'(spike), 0);
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset spike", longint'(spike), 0);
        chk("R1 reset thr", longint'(thr), longint'(base));

        // plain integrate and fire, no adaptation weight
        for (int i = 0; i < 30; i++) step(64'sh3000, "R4 R5 R6 integrate");
        for (int i = 0; i < 10; i++) step(-64'sh2000, "R4 negative input");

        // adaptation active: spikes raise the threshold
        @(negedge clk);
        beta_f = 16'hC000; beta_s = 16'h8000;
        @(negedge clk);
        chk("R2 thr after weight change", longint'(thr), ref_thr(m_t1, m_t2));
        for (int i = 0; i < 60; i++) step(64'sh6000, "R2 R3 adapt");
        for (int i = 0; i < 20; i++) step(64'sh20000, "R3 strong drive");

        // idle cycles: input toggles without a strobe
        begin
            longint held;
            held = longint'(thr);
            @(negedge clk);
            cur = 24'sh7FFFFF;
            repeat (20) @(negedge clk);
            chk("R7 thr held", longint'(thr), held);
        end
        step(0, "R7 membrane untouched by idle input");

        // silence: return to baseline
        for (int i = 0; i < 400; i++) step(0, "R8 decay");
        chk("R8 thr back to base", longint'(thr), longint'(base));

        // clear in the middle of activity
        for (int i = 0; i < 15; i++) step(64'sh8000, "R3 before clear");
        do_clear();
        for (int i = 0; i < 10; i++) step(64'sh8000, "R1 after clear");

        // rails: membrane clamps, equality does not fire
        do_clear();
        @(negedge clk);
        beta_f = '0; beta_s = '0; base = 24'sh7FFFFF;
        for (int i = 0; i < 8; i++) step(MAXV, "R4 R5 upper rail no fire");
        @(negedge clk);
        base = 24'sh7FFFFE;
        step(0, "R5 one above threshold fires");
        @(negedge clk);
        beta_f = 16'hFFFF; beta_s = 16'hFFFF; base = 24'sh7FFF00;
        @(negedge clk);
        chk("R2 thr clamps at max", longint'(thr), MAXV);
        for (int i = 0; i < 8; i++) step(MINV, "R4 lower rail");
        @(negedge clk);
        base = 24'sh000000; beta_f = 16'h4000; beta_s = 16'h4000;
        rho_f = 16'h0000; rho_s = 16'hFFFF;
        for (int i = 0; i < 40; i++) step(64'sh30000, "R3 extreme decay factors");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule